// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Target

This block is a synthesizable stand-in for a 16-bit-wide static memory with an asynchronous-style control interface. All controls are active low: a select, a read-drive enable, a write strobe, and one enable for each byte of the word. A fast internal clock samples these controls along with the address and write data. The block works out the access mode from them, stores bytes under a per-lane mask, and returns read data on a split data bus. Each byte lane has its own output-enable flag, which takes the place of a tri-state driver.

A write is open while select and the write strobe are both low. It completes on the first sampled cycle in which either of them has gone high again. The address, data and byte enables used for the store are the ones seen in the last cycle of the open window. The array depth is set by the address-width parameter. The default is 256 words, which keeps the array small; 17 address bits give the full 131072-word size.

Top module: `sram_byte_target`

## Requirements
- R1: When a write window ends with both byte enables low, the full 16-bit word is stored, and a later read of that address returns it.
- R2: A write with only the lower enable low stores bits 7:0 and leaves bits 15:8 of the word unchanged.
- R3: A write with only the upper enable low stores bits 15:8 and leaves bits 7:0 of the word unchanged.
- R4: A write window in which both byte enables are high changes no stored data.
- R5: A lane's output-enable flag (bit 0 for bits 7:0, bit 1 for bits 15:8) is set only while select is low, read-drive is low, write strobe is high and that lane's byte enable is low.
- R6: While select is high, both lane flags are clear and `standby_o` is high, whatever the other controls are. A write strobe pulse in this state stores nothing.
- R7: While select is low and both read-drive and write strobe are high, both lane flags are clear and `standby_o` is low.
- R8: While a write window is open, both lane flags are clear even if read-drive is low.
- R9: A write window that ends because select rises (with the write strobe still low) commits the write.
- R10: A write window that ends because the write strobe rises (with select still low) commits the write.
- R11: A lane whose flag is clear presents zero on its bits of `rdata_o`.
- R12: After reset, both lane flags are clear, `rdata_o` is zero and `standby_o` is high.
- R13: A change on the input pins reaches the outputs after exactly two rising clock edges: the first edge leaves the outputs unchanged, and the second edge updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Select, active low |
| rd_en_n_i | input | 1 | Read-drive enable, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| lo_en_n_i | input | 1 | Enable for bits 7:0, active low |
| hi_en_n_i | input | 1 | Enable for bits 15:8, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero on lanes that are not driven |
| lane_oe_o | output | 2 | Per-lane drive flags; bit 0 is bits 7:0 |
| standby_o | output | 1 | High while select is high |

## Verification
The bench builds the block with the default ADDR_W of 8. This makes addresses 0 and 255 the two ends of the array, so the bench can check that a write at one end does not alias onto the other. The small depth keeps every stored word within reach of a short directed sequence. That sequence covers both ways a write window can end, every byte-mask combination, and each row of the high-impedance conditions. The two-edge input latency is checked edge by edge.

// File: rtl/sram_tgt_pkg.sv
// Package: shared constants and the access-mode type of the SRAM target.
// Assumes a word made of equal-width byte lanes.
package sram_tgt_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } access_mode_e;
endpackage

// File: rtl/sram_tgt_sync.sv
// Module: two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is treated on its own; reset loads RST_VAL into both stages.
module sram_tgt_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two stages of sampling against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/sram_tgt_ctrl.sv
// Module: mode decoder and write-window tracker.
// Takes synchronized active-low controls. It decodes the access mode and the
// per-lane drive flags, and it flags the cycle in which an open write window
// closes. Byte enables are delayed by one cycle so that the lane mask of the
// last window cycle is the one applied.
module sram_tgt_ctrl
    import sram_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] ben_n,
    output logic [LANES-1:0] lane_oe,
    output logic [LANES-1:0] wr_lane,
    output logic             commit,
    output logic             standby
);
    access_mode_e     mode;
    logic             win;
    logic             win_q;
    logic [LANES-1:0] ben_q;

    // Truth-table decode: select dominates, then write, then read.
    always_comb begin
        if (sel_n)       mode = MODE_STANDBY;
        else if (!wr_n)  mode = MODE_WRITE;
        else if (!rd_n)  mode = MODE_READ;
        else             mode = MODE_IDLE;
    end

    assign win     = (mode == MODE_WRITE);
    assign standby = (mode == MODE_STANDBY);

    // Remember the window state and the lane mask of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            ben_q <= '1;
        end else begin
            win_q <= win;
            ben_q <= ben_n;
        end
    end

    // The window closes when either select or the write strobe rises.
    assign commit = win_q && !win;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_oe[g] = (mode == MODE_READ) && !ben_n[g];
            assign wr_lane[g] = commit && !ben_q[g];
        end
    endgenerate
endmodule

// File: rtl/sram_tgt_array.sv
// Module: storage array split into independent byte lanes.
// Write is synchronous and masked per lane; read is combinational from the
// read address. The contents are not reset.
module sram_tgt_array
    import sram_tgt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            // Store this lane's byte when its write strobe is set.
            always_ff @(posedge clk) begin
                if (wr_lane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end

            assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
        end
    endgenerate
endmodule

// File: rtl/sram_byte_target.sv
// Module: top of the byte-lane SRAM target.
// Synchronizes the pins and decodes the mode. Address and data of the last
// write-window cycle are kept so the store can happen on the closing edge.
// Lanes that are not driven present zero. Assumes all inputs are asynchronous
// to clk and are held for at least one clock period.
module sram_byte_target
    import sram_tgt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              rd_en_n_i,
    input  logic              wr_n_i,
    input  logic              lo_en_n_i,
    input  logic              hi_en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LANES-1:0]  lane_oe_o,
    output logic              standby_o
);
    localparam int CTL_W = 3 + LANES;
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [CTL_W-1:0]  ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              sel_s, rd_s, wr_s;
    logic [LANES-1:0]  ben_s;
    logic [ADDR_W-1:0] addr_s, addr_q;
    logic [DATA_W-1:0] data_s, data_q;
    logic [LANES-1:0]  wr_lane;
    logic              commit;
    logic [DATA_W-1:0] arr_rd;

    sram_tgt_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, rd_en_n_i, wr_n_i, hi_en_n_i, lo_en_n_i}),
        .q_o   (ctl_s)
    );

    sram_tgt_sync #(.W(BUS_W), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({addr_i, wdata_i}),
        .q_o   (bus_s)
    );

    assign {sel_s, rd_s, wr_s, ben_s} = ctl_s;
    assign {addr_s, data_s}           = bus_s;

    // Hold address and data of the previous cycle for the closing-edge store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_s;
            data_q <= data_s;
        end
    end

    sram_tgt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_s),
        .rd_n    (rd_s),
        .wr_n    (wr_s),
        .ben_n   (ben_s),
        .lane_oe (lane_oe_o),
        .wr_lane (wr_lane),
        .commit  (commit),
        .standby (standby_o)
    );

    sram_tgt_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_lane (wr_lane),
        .waddr   (addr_q),
        .wdata   (data_q),
        .raddr   (addr_s),
        .rdata   (arr_rd)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_out
            assign rdata_o[g*LANE_W +: LANE_W] =
                lane_oe_o[g] ? arr_rd[g*LANE_W +: LANE_W] : '0;
        end
    endgenerate
endmodule

// File: rtl/sram_byte_target_chk.sv
// Module: property checker for the SRAM target, attached by bind.
// Observes the synchronized controls, the store strobes and the outputs.
module sram_byte_target_chk
    import sram_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_s,
    input logic              rd_s,
    input logic              wr_s,
    input logic [LANES-1:0]  ben_s,
    input logic              commit,
    input logic [LANES-1:0]  wr_lane,
    input logic [LANES-1:0]  lane_oe_o,
    input logic              standby_o,
    input logic [DATA_W-1:0] rdata_o
);
    // R6: standby never drives a lane.
    p_standby_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |-> (standby_o && lane_oe_o == '0));

    // R7: selected with outputs disabled drives nothing.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && rd_s && wr_s) |-> (!standby_o && lane_oe_o == '0));

    // R8: no lane is driven inside a write window.
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !wr_s) |-> (lane_oe_o == '0));

    // R5: the lower lane drives only with its enable low.
    p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe_o[0] |-> (!ben_s[0] && !rd_s && wr_s));

    // R9 and R10: a store follows an open window closed by select or strobe.
    p_commit_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(!sel_s && !wr_s) && (sel_s || wr_s)));

    // R4: a window with both enables high stores nothing.
    p_no_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && $past(ben_s == '1)) |-> (wr_lane == '0));

    // R11: an undriven upper lane presents zero.
    p_zero_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_oe_o[1] |-> (rdata_o[DATA_W-1 -: LANE_W] == '0));
endmodule

bind sram_byte_target sram_byte_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .rd_s      (rd_s),
    .wr_s      (wr_s),
    .ben_s     (ben_s),
    .commit    (commit),
    .wr_lane   (wr_lane),
    .lane_oe_o (lane_oe_o),
    .standby_o (standby_o),
    .rdata_o   (rdata_o)
);

// File: tb/sram_byte_target_test.sv
// Scoreboard bench: driver tasks push expected output sets into a queue; the
// monitor pops one each falling edge and compares it with the outputs.
module sram_byte_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    typedef struct {
        logic [1:0]  oe;
        logic [15:0] data;
        logic        sb;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    lane_oe;
    logic          standby;

    exp_t exp_q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_byte_target #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_i   (sel_n),
        .rd_en_n_i (rd_n),
        .wr_n_i    (wr_n),
        .lo_en_n_i (lo_n),
        .hi_en_n_i (hi_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .lane_oe_o (lane_oe),
        .standby_o (standby)
    );

    // Monitor: compare one queued expectation per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_checks++;
            if (lane_oe !== cur.oe || rdata !== cur.data || standby !== cur.sb) begin
                n_errors++;
                $display("FAIL %s: oe=%b data=%h sb=%b expected oe=%b data=%h sb=%b",
                         cur.tag, lane_oe, rdata, standby, cur.oe, cur.data, cur.sb);
            end
        end
    end

    task automatic drive(input logic s, input logic r, input logic w,
                         input logic lo, input logic hi,
                         input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        sel_n = s; rd_n = r; wr_n = w; lo_n = lo; hi_n = hi; addr = a; wdata = d;
    endtask

    task automatic push(input logic [1:0] oe, input logic [15:0] d,
                        input logic sb, input string tag);
        exp_t e;
        e.oe = oe; e.data = d; e.sb = sb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Let inputs settle through synchronizer and store, then queue a check.
    task automatic expect_out(input logic [1:0] oe, input logic [15:0] d,
                              input logic sb, input string tag);
        repeat (4) @(posedge clk);
        #1;
        push(oe, d, sb, tag);
        @(negedge clk);
        #1;
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Write window closed by the strobe rising, select held low.
    task automatic write_by_strobe(input logic [AW-1:0] a, input logic [15:0] d,
                                   input logic lo, input logic hi);
        drive(0, 1, 1, lo, hi, a, d); hold(2);
        drive(0, 1, 0, lo, hi, a, d); hold(3);
        drive(0, 1, 1, lo, hi, a, d); hold(4);
    endtask

    // Write window closed by select rising, strobe still low.
    task automatic write_by_select(input logic [AW-1:0] a, input logic [15:0] d,
                                   input logic lo, input logic hi);
        drive(1, 1, 0, lo, hi, a, d); hold(2);
        drive(0, 1, 0, lo, hi, a, d); hold(3);
        drive(1, 1, 0, lo, hi, a, d); hold(3);
        drive(1, 1, 1, lo, hi, a, d); hold(4);
    endtask

    task automatic read_word(input logic [AW-1:0] a, input logic lo, input logic hi,
                             input logic [1:0] oe, input logic [15:0] d, input string tag);
        drive(0, 0, 1, lo, hi, a, 16'h0000);
        expect_out(oe, d, 1'b0, tag);
    endtask

    initial begin
        hold(3);
        @(negedge clk); rst_n = 1'b1;
        // R12: reset state.
        expect_out(2'b00, 16'h0000, 1'b1, "R12 reset state");

        // R1: full-word write closed by strobe.
        write_by_strobe(8'd3, 16'hA55A, 0, 0);
        read_word(8'd3, 0, 0, 2'b11, 16'hA55A, "R1 full word");
        // R5/R11: single-lane reads.
        read_word(8'd3, 0, 1, 2'b01, 16'h005A, "R5 R11 lower lane only");
        read_word(8'd3, 1, 0, 2'b10, 16'hA500, "R5 R11 upper lane only");
        read_word(8'd3, 1, 1, 2'b00, 16'h0000, "R5 no lane enabled");
        // R2: lower-byte write.
        write_by_strobe(8'd3, 16'h1234, 0, 1);
        read_word(8'd3, 0, 0, 2'b11, 16'hA534, "R2 lower byte only");
        // R3: upper-byte write.
        write_by_strobe(8'd3, 16'h7799, 1, 0);
        read_word(8'd3, 0, 0, 2'b11, 16'h7734, "R3 upper byte only");
        // R4: no byte enabled.
        write_by_strobe(8'd3, 16'hFFFF, 1, 1);
        read_word(8'd3, 0, 0, 2'b11, 16'h7734, "R4 no byte enabled");
        // R9: select-ended write.
        write_by_select(8'd200, 16'hBEEF, 0, 0);
        read_word(8'd200, 0, 0, 2'b11, 16'hBEEF, "R9 select ends write");
        // R10: strobe-ended write at both array ends.
        write_by_strobe(8'd255, 16'h0F0F, 0, 0);
        write_by_strobe(8'd0, 16'hC3C3, 0, 0);
        read_word(8'd255, 0, 0, 2'b11, 16'h0F0F, "R10 strobe ends write top");
        read_word(8'd0, 0, 0, 2'b11, 16'hC3C3, "R10 strobe ends write bottom");

        // R6: deselected with read controls active.
        drive(1, 0, 1, 0, 0, 8'd200, 16'h0000);
        expect_out(2'b00, 16'h0000, 1'b1, "R6 standby drives nothing");
        // R6: strobe pulse while deselected stores nothing.
        drive(1, 1, 0, 0, 0, 8'd200, 16'h0000); hold(3);
        drive(1, 1, 1, 0, 0, 8'd200, 16'h0000); hold(3);
        read_word(8'd200, 0, 0, 2'b11, 16'hBEEF, "R6 strobe while deselected");

        // R7: selected, outputs disabled.
        drive(0, 1, 1, 0, 0, 8'd200, 16'h0000);
        expect_out(2'b00, 16'h0000, 1'b0, "R7 outputs disabled");

        // R8: read-drive low inside a write window.
        drive(0, 0, 1, 0, 0, 8'd9, 16'h1111); hold(2);
        drive(0, 0, 0, 0, 0, 8'd9, 16'h1111);
        expect_out(2'b00, 16'h0000, 1'b0, "R8 write window quiet");
        drive(0, 1, 1, 0, 0, 8'd9, 16'h1111); hold(4);
        read_word(8'd9, 0, 0, 2'b11, 16'h1111, "R10 R8 window write stored");

        // R13: edge-by-edge latency from idle to read.
        drive(0, 1, 1, 0, 0, 8'd255, 16'h0000); hold(4);
        @(negedge clk); rd_n = 1'b0;
        @(posedge clk); #1;
        push(2'b00, 16'h0000, 1'b0, "R13 unchanged after one edge");
        @(posedge clk); #1;
        push(2'b11, 16'h0F0F, 1'b0, "R13 updated after two edges");
        @(negedge clk); #1;

        hold(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule